// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a bus-programmed serial peripheral interface master. Software sets a divider and a control word over a small 32-bit register bus. It then pushes data words into a transmit queue and pulls received words out of a receive queue. The block shifts each word out on the serial data output and samples the serial data input at the edge the chosen SPI mode calls for. Clock polarity, clock phase, bit order and word length (2 to 16 bits) are all programmable. An internal loopback path can replace the external input.

Device selection is handled outside the block by a general-purpose pin, so there is no select output. A level interrupt tells software when everything it queued has left the shifter. A register slot kept for an alternate two-wire mode accepts writes but has no effect.

Top module: `spim_ctrl`

## Requirements
- R1: Register word offsets are 0x00 divider, 0x04 transmit push, 0x08 receive pop, 0x0C control, 0x10 interrupt enable. After reset the divider, control and interrupt enable registers read 0, a receive read returns 0, and SCK and the interrupt are low.
- R2: While a word is shifting, SCK toggles every D system clocks, where D is the divider value. A divider value of 0 counts as 2^DIV_W (65536 by default).
- R3: Control bits [3:0] hold the word length minus one. Received words are right-aligned and zero-extended, and transmit bits above the word length are not sent.
- R4: Control bit 4 set sends and receives the most significant bit first. Clear sends and receives the least significant bit first.
- R5: Control bit 6 sets the SCK idle level. Control bit 5 clear samples on the leading edge and changes data on the trailing edge. Bit 5 set changes data on the leading edge and samples on the trailing edge.
- R6: Control bit 10 feeds the serial output back into the receive path, and the external input is then ignored.
- R7: Each queue holds FIFO_DEPTH (8) words while its enable bit is set: bit 11 for transmit, bit 12 for receive. With the bit clear, the queue holds one word. A transmit write to a full queue is dropped.
- R8: A word that arrives while the receive queue is full is discarded. A read of an empty receive queue returns 0.
- R9: A word starts shifting only when control bit 9 (enable) and bit 8 (master) are both set and the transmit queue is not empty.
- R10: While control bit 7 is set, both queues and the shifter are cleared, and words written during that time are never sent.
- R11: When interrupt-enable bit 2 is set, the interrupt is high exactly when the transmit queue is empty and the shifter is idle. It is low while a word is shifting.
- R12: Word length, bit order, phase, loopback and divider are captured when a word starts. A control write made during a word takes effect from the next word.
- R13: Writes to offset 0x18 are accepted, have no effect on any register or transfer, and the offset reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| miso_i | input | 1 | Serial data input |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data output |
| irq_o | output | 1 | Level interrupt: all transmit work done |

## Verification
The assertions assume that a read strobe and a write strobe never arrive in the same cycle. They also assume the clock polarity bit changes only while the shifter is idle, since the idle-level check compares SCK against the polarity of the previous cycle. The bench keeps to these rules: it issues one bus command at a time, separated by an idle cycle, and it reprograms polarity only between words. It also keeps the divider at 7 or more, apart from the single zero-divider case, so that the slave model's edge bookkeeping sees clean half periods.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Register word indices (byte offset / 4)
  localparam int REG_DIV = 0;
  localparam int REG_TX  = 1;
  localparam int REG_RX  = 2;
  localparam int REG_CTL = 3;
  localparam int REG_IEN = 4;
  localparam int REG_ALT = 6;

  localparam int CTL_W      = 13;
  localparam int IEB_TXDONE = 2;

  // Control word, bit 12 down to bit 0
  typedef struct packed {
    logic       rxf_on;  // 12
    logic       txf_on;  // 11
    logic       loop;    // 10
    logic       en;      // 9
    logic       master;  // 8
    logic       srst;    // 7
    logic       cpol;    // 6
    logic       cpha;    // 5
    logic       msb;     // 4
    logic [3:0] len_m1;  // 3:0
  } ctl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         limit_one,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  always_comb begin
    full    = limit_one ? (cnt != '0) : (cnt == CW'(DEPTH));
    empty   = (cnt == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    dout    = mem[rp];
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (cnt == $past(cnt))) else $error("push into full queue changed count"); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !flush) |=> empty) else $error("pop from empty queue left data"); // R8
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, lim;

  // div - 1 wraps a zero divider to the full 2^DIV_W period
  always_comb begin
    lim  = div - 1'b1;
    tick = run && (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DIV_W = 16,
  parameter int MAXW  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     srst_i,
  input  logic                     go_i,
  input  logic                     tx_avail_i,
  input  logic [MAXW-1:0]          tx_word_i,
  input  logic [$clog2(MAXW)-1:0]  len_m1_i,
  input  logic                     msb_i,
  input  logic                     cpha_i,
  input  logic                     cpol_i,
  input  logic                     loop_i,
  input  logic [DIV_W-1:0]         div_i,
  input  logic                     miso_i,
  output logic                     tx_pop_o,
  output logic                     rx_push_o,
  output logic [MAXW-1:0]          rx_word_o,
  output logic                     busy_o,
  output logic                     sck_o,
  output logic                     mosi_o
);
  localparam int LW = $clog2(MAXW);

  logic            busy_q, half_q, first_q, sck_q, mosi_q;
  logic            msb_q, cpha_q, loop_q, rx_push_q;
  logic [LW-1:0]   bit_q, len_q, bit_nx;
  logic [MAXW-1:0] word_q, acc_q, acc_nx, rx_word_q;
  logic [DIV_W-1:0] div_q;
  logic            tick, start, lead, trail, samp, last, adv, miso_eff;

  function automatic logic [LW-1:0] pos(input logic m, input logic [LW-1:0] l,
                                        input logic [LW-1:0] i);
    return m ? (l - i) : i;
  endfunction

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .div  (div_q),
    .tick (tick)
  );

  always_comb begin
    start    = !busy_q && go_i && tx_avail_i && !srst_i;
    lead     = tick && !half_q;
    trail    = tick && half_q;
    samp     = cpha_q ? trail : lead;
    miso_eff = loop_q ? mosi_q : miso_i;
    acc_nx   = acc_q;
    if (samp) acc_nx[pos(msb_q, len_q, bit_q)] = miso_eff;
    last     = trail && (bit_q == len_q);
    adv      = cpha_q ? (lead && !first_q) : (trail && (bit_q != len_q));
    bit_nx   = bit_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; half_q <= 1'b0; first_q <= 1'b0; sck_q <= 1'b0;
      mosi_q <= 1'b0; msb_q <= 1'b0; cpha_q <= 1'b0; loop_q <= 1'b0;
      rx_push_q <= 1'b0; bit_q <= '0; len_q <= '0; word_q <= '0;
      acc_q <= '0; rx_word_q <= '0; div_q <= '0;
    end else if (srst_i) begin
      busy_q    <= 1'b0;
      rx_push_q <= 1'b0;
      sck_q     <= cpol_i;
    end else begin
      rx_push_q <= 1'b0;
      if (start) begin
        busy_q  <= 1'b1;
        half_q  <= 1'b0;
        first_q <= 1'b1;
        bit_q   <= '0;
        len_q   <= len_m1_i;
        msb_q   <= msb_i;
        cpha_q  <= cpha_i;
        loop_q  <= loop_i;
        div_q   <= div_i;
        word_q  <= tx_word_i;
        acc_q   <= '0;
        mosi_q  <= tx_word_i[pos(msb_i, len_m1_i, '0)];
      end else if (busy_q) begin
        if (tick) begin
          sck_q  <= ~sck_q;
          half_q <= ~half_q;
        end
        if (lead) first_q <= 1'b0;
        acc_q <= acc_nx;
        if (adv) begin
          bit_q  <= bit_nx;
          mosi_q <= word_q[pos(msb_q, len_q, bit_nx)];
        end
        if (last) begin
          busy_q    <= 1'b0;
          rx_push_q <= 1'b1;
          rx_word_q <= acc_nx;
        end
      end else begin
        sck_q <= cpol_i;
      end
    end
  end

  assign tx_pop_o  = start;
  assign rx_push_o = rx_push_q;
  assign rx_word_o = rx_word_q;
  assign busy_o    = busy_q;
  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q)) |-> (sck_q == $past(cpol_i))) else $error("SCK not at idle level"); // R5

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(go_i && tx_avail_i)) else $error("word started without permission"); // R9
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int MAXW       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              irq_o
);
  localparam int LW = $clog2(MAXW);

  ctl_t             ctl_q;
  logic [DIV_W-1:0] div_q;
  logic             ien_q, irq_q;
  logic [31:0]      rdata_q;
  logic [ADDR_W-3:0] sel;
  logic             tx_wr, rx_rd, tx_pop, tx_empty, rx_empty, rx_push, busy, go;
  logic [MAXW-1:0]  tx_dout, rx_dout, rx_word;
  logic             unused_bits;

  always_comb begin
    sel   = bus_addr[ADDR_W-1:2];
    tx_wr = bus_wr && (int'(sel) == REG_TX);
    rx_rd = bus_rd && (int'(sel) == REG_RX);
    go    = ctl_q.en && ctl_q.master;
  end

  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      ctl_q   <= '0;
      ien_q   <= 1'b0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (int'(sel))
          REG_DIV: div_q <= bus_wdata[DIV_W-1:0];
          REG_CTL: ctl_q <= ctl_t'(bus_wdata[CTL_W-1:0]);
          REG_IEN: ien_q <= bus_wdata[IEB_TXDONE];
          default: ;
        endcase
      end
      if (bus_rd) begin
        case (int'(sel))
          REG_DIV: rdata_q <= 32'(div_q);
          REG_CTL: rdata_q <= 32'(ctl_q);
          REG_IEN: rdata_q <= 32'(ien_q) << IEB_TXDONE;
          REG_RX:  rdata_q <= rx_empty ? '0 : 32'(rx_dout);
          default: rdata_q <= '0;
        endcase
      end
      irq_q <= ien_q && tx_empty && !busy;
    end
  end

  spim_fifo #(.W(MAXW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctl_q.srst),
    .limit_one (!ctl_q.txf_on),
    .push      (tx_wr),
    .din       (bus_wdata[MAXW-1:0]),
    .pop       (tx_pop),
    .dout      (tx_dout),
    .empty     (tx_empty)
  );

  spim_fifo #(.W(MAXW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .flush     (ctl_q.srst),
    .limit_one (!ctl_q.rxf_on),
    .push      (rx_push),
    .din       (rx_word),
    .pop       (rx_rd),
    .dout      (rx_dout),
    .empty     (rx_empty)
  );

  spim_shifter #(.DIV_W(DIV_W), .MAXW(MAXW)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .srst_i     (ctl_q.srst),
    .go_i       (go),
    .tx_avail_i (!tx_empty),
    .tx_word_i  (tx_dout),
    .len_m1_i   (LW'(ctl_q.len_m1)),
    .msb_i      (ctl_q.msb),
    .cpha_i     (ctl_q.cpha),
    .cpol_i     (ctl_q.cpol),
    .loop_i     (ctl_q.loop),
    .div_i      (div_q),
    .miso_i     (miso_i),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_word_o  (rx_word),
    .busy_o     (busy),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o)
  );

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !irq_q) else $error("interrupt while shifting"); // R11

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rx_rd && rx_empty) |=> (bus_rdata == '0)) else $error("empty receive read not zero"); // R8
endmodule

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;
  localparam int DW = 6;
  localparam int A_DIV = 'h00, A_TX = 'h04, A_RX = 'h08, A_CTL = 'h0C, A_IEN = 'h10, A_ALT = 'h18;
  localparam int MSB = 1 << 4, CPHA = 1 << 5, CPOL = 1 << 6, SR = 1 << 7, MS = 1 << 8;
  localparam int EN = 1 << 9, LOOP = 1 << 10, TXF = 1 << 11, RXF = 1 << 12;
  localparam int BASE = EN | MS | TXF | RXF;

  logic clk = 0, rst = 1;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0, miso = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, irq;

  spim_ctrl #(.ADDR_W(5), .DIV_W(DW), .FIFO_DEPTH(8), .MAXW(16)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .miso_i(miso),
    .sck_o(sck), .mosi_o(mosi), .irq_o(irq));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // behavioural SPI slave and reference
  bit slv_on = 0, cpol_b = 0, cpha_b = 0, msb_b = 0;
  int exp_div = 7, cyc = 0, last_edge = 0, edges = 0, scnt = 0, cur_n = 8, acc = 0;
  int words_seen = 0;
  logic prev_sck = 0;
  int len_q[$], txexp_q[$], miso_q[$], rxq[$];

  always @(negedge clk) begin
    int e, n_now, s_now;
    bit lead;
    cyc++;
    if (slv_on && !rst && sck !== prev_sck) begin
      if (edges == 0) begin
        cur_n = (len_q.size() > 0) ? len_q[0] : 8;
        acc = 0; scnt = 0;
      end else
        chk((cyc - last_edge) == exp_div, "R2", "SCK half period", cyc - last_edge, exp_div);
      last_edge = cyc;
      lead = (prev_sck == cpol_b);
      if (cpha_b ? !lead : lead) begin
        if (mosi === 1'b1) acc |= (1 << (msb_b ? cur_n - 1 - scnt : scnt));
        scnt++;
      end
      edges++;
      if (edges == 2 * cur_n) begin
        e = (txexp_q.size() > 0) ? txexp_q.pop_front() : -1;
        chk(acc == e, "R4 R5", "word seen on MOSI", acc, e);
        if (len_q.size() > 0) len_q.delete(0);
        if (miso_q.size() > 0) miso_q.delete(0);
        words_seen++;
        edges = 0;
      end
    end
    prev_sck = sck;
    n_now = (edges == 0) ? ((len_q.size() > 0) ? len_q[0] : 8) : cur_n;
    s_now = (edges == 0) ? 0 : scnt;
    if (miso_q.size() > 0 && s_now < n_now)
      miso = 1'((miso_q[0] >> (msb_b ? n_now - 1 - s_now : s_now)) & 1);
    else
      miso = 1'b0;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_wr = 1; bus_addr = 5'(a); bus_wdata = 32'(d);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); bus_rd = 1; bus_addr = 5'(a);
    @(negedge clk); bus_rd = 0; v = int'(bus_rdata);
  endtask

  task automatic rd_chk(input int a, input int exp, input string req, input string what);
    int v;
    rd(a, v);
    chk(v == exp, req, what, v, exp);
  endtask

  task automatic cfg(input int c, input int d);
    slv_on = 0;
    wr(A_DIV, d);
    wr(A_CTL, c);
    cpol_b = (c & CPOL) != 0; cpha_b = (c & CPHA) != 0; msb_b = (c & MSB) != 0;
    exp_div = (d == 0) ? (1 << DW) : d;
    repeat (2) @(negedge clk);
    slv_on = 1;
  endtask

  task automatic send(input int w, input int n, input int m);
    len_q.push_back(n);
    txexp_q.push_back(w & ((1 << n) - 1));
    miso_q.push_back(m & ((1 << n) - 1));
    wr(A_TX, w);
  endtask

  task automatic wait_words(input int target);
    int t = 0;
    while (words_seen < target && t < 20000) begin @(negedge clk); t++; end
    chk(words_seen >= target, "R9", "words completed", words_seen, target);
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input string req);
    while (rxq.size() > 0) rd_chk(A_RX, rxq.pop_front(), req, "received word");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(sck == 1'b0, "R1", "sck after reset", int'(sck), 0);
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    rd_chk(A_CTL, 0, "R1", "control after reset");
    rd_chk(A_DIV, 0, "R1", "divider after reset");
    rd_chk(A_IEN, 0, "R1", "irq enable after reset");
    rd_chk(A_RX, 0, "R1", "receive after reset");

    // mode 0, 8-bit, MSB first
    cfg(BASE | MSB | 7, 7);
    wr(A_IEN, 4);
    rd_chk(A_IEN, 4, "R1", "irq enable readback");
    send('hA5, 8, 'h3C); rxq.push_back('h3C);
    send('h01, 8, 'h80); rxq.push_back('h80);
    send('hFF, 8, 'h00); rxq.push_back('h00);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R11", "irq while shifting", int'(irq), 0);
    wait_words(3);
    chk(irq == 1'b1, "R11", "irq after drain", int'(irq), 1);
    drain("R3 R5");
    rd_chk(A_RX, 0, "R8", "read of empty receive queue");

    // mode 3, 16-bit, LSB first
    cfg(BASE | CPOL | CPHA | 15, 8);
    w0 = words_seen;
    send('hBEEF, 16, 'h1234); rxq.push_back('h1234);
    send('h8001, 16, 'hF00F); rxq.push_back('hF00F);
    wait_words(w0 + 2);
    chk(sck == 1'b1, "R5", "sck idles high with polarity set", int'(sck), 1);
    drain("R4 R5");

    // mode 1, 12-bit, loopback: external input ignored
    cfg(BASE | CPHA | LOOP | MSB | 11, 7);
    w0 = words_seen;
    send('hFABC, 12, 'h555); rxq.push_back('hABC);
    send('h0F0, 12, 'hFFF); rxq.push_back('h0F0);
    wait_words(w0 + 2);
    drain("R6 R3");

    // overflow of transmit queue, then full receive queue
    cfg(MS | TXF | RXF | MSB | 7, 7);
    w0 = words_seen;
    for (int i = 0; i < 8; i++) begin send('h10 + i, 8, 'h40 + i); rxq.push_back('h40 + i); end
    wr(A_TX, 'h77); wr(A_TX, 'h78);
    wr(A_CTL, BASE | MSB | 7);
    wait_words(w0 + 8);
    repeat (200) @(negedge clk);
    chk(words_seen == w0 + 8, "R7", "words sent after overfill", words_seen, w0 + 8);
    send('h21, 8, 'h61); send('h22, 8, 'h62);
    wait_words(w0 + 10);
    drain("R8");
    rd_chk(A_RX, 0, "R8", "words into full queue discarded");

    // queues switched to single-entry
    cfg(MS | MSB | 7, 7);
    w0 = words_seen;
    send('h33, 8, 'h91); rxq.push_back('h91);
    wr(A_TX, 'h34); wr(A_TX, 'h35);
    wr(A_CTL, EN | MS | MSB | 7);
    wait_words(w0 + 1);
    repeat (200) @(negedge clk);
    chk(words_seen == w0 + 1, "R7", "single-entry transmit queue", words_seen, w0 + 1);
    send('h36, 8, 'h92);
    wait_words(w0 + 2);
    drain("R7");
    rd_chk(A_RX, 0, "R7", "single-entry receive queue");

    // zero divider
    cfg(BASE | MSB | 7, 0);
    w0 = words_seen;
    send('h5A, 8, 'hC3); rxq.push_back('hC3);
    wait_words(w0 + 1);
    drain("R2");

    // soft reset clears queued words
    cfg(MS | TXF | RXF | MSB | 7, 7);
    w0 = words_seen;
    wr(A_TX, 'h11); wr(A_TX, 'h12); wr(A_TX, 'h13);
    wr(A_CTL, MS | TXF | RXF | SR | MSB | 7);
    wr(A_CTL, BASE | MSB | 7);
    repeat (300) @(negedge clk);
    chk(words_seen == w0, "R10", "words sent after soft reset", words_seen, w0);
    chk(irq == 1'b1, "R11", "irq with empty queue", int'(irq), 1);
    rd_chk(A_RX, 0, "R10", "receive after soft reset");

    // master bit gates start
    cfg(EN | TXF | RXF | MSB | 7, 7);
    w0 = words_seen;
    send('h6C, 8, 'h2D); rxq.push_back('h2D);
    repeat (300) @(negedge clk);
    chk(words_seen == w0, "R9", "no shifting without master", words_seen, w0);
    wr(A_CTL, BASE | MSB | 7);
    wait_words(w0 + 1);
    drain("R9");

    // length change during a word
    cfg(BASE | MSB | 15, 7);
    w0 = words_seen;
    send('hC3A5, 16, 'h0F0F); rxq.push_back('h0F0F);
    send('h96, 8, 'h5A); rxq.push_back('h5A);
    repeat (30) @(negedge clk);
    wr(A_CTL, BASE | MSB | 7);
    wait_words(w0 + 2);
    drain("R12");

    // alternate-mode slot ignored
    wr(A_ALT, -1);
    rd_chk(A_ALT, 0, "R13", "alternate slot reads zero");
    rd_chk(A_CTL, BASE | MSB | 7, "R13", "control unchanged");
    w0 = words_seen;
    send('h81, 8, 'h18); rxq.push_back('h18);
    wait_words(w0 + 1);
    drain("R13");

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule